// File: doc/BRIEF.md
# Eight-Channel Trigger Hit Detector

This block watches eight parallel streams of 10-bit ADC samples and decides, for each accepted sample, whether each channel shows a trigger hit. All eight channels share one algorithm choice: a short three-sample step detector, or a slower detector that compares two adjacent eight-sample sums and can fire on either pulse polarity. Before detection every sample passes through two shared conditioning controls, one that forces it to zero and one that inverts all of its bits. A per-channel trigger mask then gates the hits.

Samples enter as one 80-bit beat on a valid/ready input. Ready is held high, so the input never applies back-pressure, and a beat counts as taken on any clock where valid is high. Clocks with valid low leave the sample history unchanged. Each taken beat yields one result beat one clock later. That beat carries the eight masked hit bits and their grand-OR. A second result, the count of masked hits, follows one clock after the hit bits. The two result outputs have valid strobes but no ready. Their consumer must accept every beat. Configuration inputs are plain levels, and they are sampled in the same clock as the sample they apply to.

Top module: `trg_hit_det`

## Requirements
- R1: While reset is asserted and on the first clock after it, hit_vld, hits, any_hit, mult_vld and mult are all zero.
- R2: s_ready is 1. Every clock with s_valid high takes one sample beat and raises hit_vld on the next clock. A clock with s_valid low raises no hit_vld and leaves the sample history unchanged.
- R3: With cfg_alt = 0, channel c hits when x(n) − x(n−3) ≥ cfg_thr. Here x(n) is the channel's conditioned sample and x(n−3) is the sample taken three beats earlier. cfg_thr is read as a signed 16-bit value.
- R4: With cfg_alt = 1, let D be the sum of the eight newest samples (the current one included) minus the sum of the eight samples before them. Let Q be D shifted right arithmetically by 2. If cfg_thr ≥ 0 the channel hits when Q ≥ cfg_thr. If cfg_thr < 0 (bit 15 set) it hits when Q ≤ cfg_thr.
- R5: The conditioned sample is x = (raw AND NOT {10{cfg_dis}}) XOR {10{cfg_pol}}. So cfg_dis = 1 with cfg_pol = 0 gives x = 0, and cfg_dis = 1 with cfg_pol = 1 gives x = 1023.
- R6: After reset the history holds zeros. No hit is reported for the first 15 beats taken, and hits are possible from the 16th beat on.
- R7: hits[c] is the channel-c decision ANDed with cfg_mask[c], with channel c on bits [10c+9:10c] of s_data. A mask of 0 gives no hits. any_hit is 1 exactly when some bit of hits is 1.
- R8: mult_vld follows hit_vld by one clock. mult then equals the number of ones in the hits value of that previous clock, which is a value from 0 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Sample beat present |
| s_ready | output | 1 | Always 1; no back-pressure |
| s_data | input | 80 | Eight 10-bit samples, channel c at bits [10c+9:10c] |
| cfg_alt | input | 1 | 0: three-sample step detector, 1: windowed-sum detector |
| cfg_pol | input | 1 | Invert all sample bits |
| cfg_dis | input | 1 | Force samples to zero |
| cfg_thr | input | 16 | Signed trigger threshold |
| cfg_mask | input | 8 | Per-channel trigger enable |
| hit_vld | output | 1 | hits and any_hit are valid |
| hits | output | 8 | Masked hit bit per channel |
| any_hit | output | 1 | Grand-OR of hits |
| mult_vld | output | 1 | mult is valid |
| mult | output | 4 | Count of masked hits |

## Verification
When beats arrive back to back, the count of masked hits for beat n appears in the same clock as the hit bits for beat n+1. A fault in the pipeline alignment could therefore mix the two. The bench provokes this case with long runs of consecutive valid beats broken by random gaps. In every clock it compares hits against a model result for the newest beat and mult against the popcount of the model result for the beat before it. The sweep covers both algorithms, both conditioning controls, positive, zero and negative thresholds, and full, empty and partial masks.

// File: rtl/trg_pkg.sv
package trg_pkg;
  localparam int NCH   = 8;   // channels per group
  localparam int SW    = 10;  // sample width
  localparam int TW    = 16;  // threshold width
  localparam int DEPTH = 16;  // samples spanned by the windowed detector
  localparam int LAG   = 3;   // step detector lag in beats
  localparam int MW    = $clog2(NCH + 1);
endpackage

// File: rtl/trg_cond.sv
module trg_cond #(
  parameter int NCH = trg_pkg::NCH,
  parameter int SW  = trg_pkg::SW
) (
  input  logic [NCH*SW-1:0] raw,
  input  logic              dis,
  input  logic              pol,
  output logic [NCH*SW-1:0] cond
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign cond[c*SW +: SW] = (raw[c*SW +: SW] & ~{SW{dis}}) ^ {SW{pol}};
  end
endmodule

// File: rtl/trg_chan.sv
module trg_chan #(
  parameter int SW    = trg_pkg::SW,
  parameter int TW    = trg_pkg::TW,
  parameter int DEPTH = trg_pkg::DEPTH,
  parameter int LAG   = trg_pkg::LAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [SW-1:0] x,
  input  logic          alt,
  input  logic [TW-1:0] thr,
  output logic          hit
);
  localparam int HALF = DEPTH / 2;
  localparam int SUMW = SW + $clog2(HALF);
  localparam int DIFW = SUMW + 1;
  localparam int CMPW = ((TW > DIFW) ? TW : DIFW) + 1;

  // hist[0] is the previous sample, hist[DEPTH-2] the oldest kept
  logic [SW-1:0] hist [DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH - 1; i++) hist[i] <= '0;
    end else if (acc) begin
      hist[0] <= x;
      for (int i = 1; i < DEPTH - 1; i++) hist[i] <= hist[i-1];
    end
  end

  logic [SUMW-1:0]        sum_new, sum_old;
  logic signed [DIFW-1:0] diff, quarter;
  logic signed [SW:0]     step;
  logic signed [CMPW-1:0] thr_x, step_x, quarter_x;
  logic                   std_hit, alt_hit;

  always_comb begin
    sum_new = SUMW'(x);
    for (int i = 0; i < HALF - 1; i++) sum_new = sum_new + SUMW'(hist[i]);
    sum_old = '0;
    for (int i = HALF - 1; i < DEPTH - 1; i++) sum_old = sum_old + SUMW'(hist[i]);
    diff      = $signed({1'b0, sum_new}) - $signed({1'b0, sum_old});
    quarter   = diff >>> 2;
    step      = $signed({1'b0, x}) - $signed({1'b0, hist[LAG-1]});
    thr_x     = CMPW'($signed(thr));
    step_x    = CMPW'(step);
    quarter_x = CMPW'(quarter);
    std_hit   = (step_x >= thr_x);
    alt_hit   = thr[TW-1] ? (quarter_x <= thr_x) : (quarter_x >= thr_x);
    hit       = alt ? alt_hit : std_hit;
  end

  // R4: eight 10-bit samples per window keep the quarter difference within +/- 2046
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (quarter_x <= CMPW'(2046)) && (quarter_x >= -CMPW'(2047)));
endmodule

// File: rtl/trg_popcnt.sv
module trg_popcnt #(
  parameter int N  = trg_pkg::NCH,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) count = count + CW'(bits[i]);
  end
endmodule

// File: rtl/trg_hit_det.sv
module trg_hit_det #(
  parameter int NCH   = trg_pkg::NCH,
  parameter int SW    = trg_pkg::SW,
  parameter int TW    = trg_pkg::TW,
  parameter int DEPTH = trg_pkg::DEPTH,
  parameter int LAG   = trg_pkg::LAG,
  parameter int MW    = $clog2(NCH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [NCH*SW-1:0] s_data,
  input  logic              cfg_alt,
  input  logic              cfg_pol,
  input  logic              cfg_dis,
  input  logic [TW-1:0]     cfg_thr,
  input  logic [NCH-1:0]    cfg_mask,
  output logic              hit_vld,
  output logic [NCH-1:0]    hits,
  output logic              any_hit,
  output logic              mult_vld,
  output logic [MW-1:0]     mult
);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic              acc;
  logic [NCH*SW-1:0] cond;
  logic [NCH-1:0]    raw_hit, gated;
  logic [CNTW-1:0]   seen;
  logic              primed;
  logic [MW-1:0]     pop;

  assign s_ready = 1'b1;
  assign acc     = s_valid & s_ready;

  trg_cond #(.NCH(NCH), .SW(SW)) u_cond (
    .raw(s_data), .dis(cfg_dis), .pol(cfg_pol), .cond(cond)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    trg_chan #(.SW(SW), .TW(TW), .DEPTH(DEPTH), .LAG(LAG)) u_chan (
      .clk(clk), .rst_n(rst_n), .acc(acc), .x(cond[c*SW +: SW]),
      .alt(cfg_alt), .thr(cfg_thr), .hit(raw_hit[c])
    );
  end

  // warm-up: beats taken since reset, saturating at DEPTH
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      seen <= '0;
    else if (acc && seen != DEPTH[CNTW-1:0]) seen <= seen + 1'b1;
  end
  assign primed = (seen >= CNTW'(DEPTH - 1));
  assign gated  = raw_hit & cfg_mask & {NCH{primed}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_vld <= 1'b0;
      hits    <= '0;
      any_hit <= 1'b0;
    end else begin
      hit_vld <= acc;
      hits    <= acc ? gated : '0;
      any_hit <= acc && (gated != '0);
    end
  end

  trg_popcnt #(.N(NCH), .CW(MW)) u_pop (.bits(hits), .count(pop));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_vld <= 1'b0;
      mult     <= '0;
    end else begin
      mult_vld <= hit_vld;
      mult     <= hit_vld ? pop : '0;
    end
  end

  a_r2_beat_to_result: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |=> hit_vld);
  a_r2_idle_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> !hit_vld);
  a_r7_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |=> (hits & ~$past(cfg_mask)) == '0);
  a_r7_grand_or: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vld |-> (any_hit == (hits != '0)));
  a_r8_mult_follows: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vld |=> mult_vld && (mult == MW'($countones($past(hits)))));
  a_r8_mult_range: assert property (@(posedge clk) disable iff (!rst_n)
    mult <= MW'(NCH));
  a_r6_quiet_warmup: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> $past(seen) >= CNTW'(DEPTH - 1));
endmodule

// File: tb/sim_trg_hit_det.sv
`timescale 1ns/1ps
module sim_trg_hit_det;
  localparam int NCH = 8;
  localparam int SW  = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [79:0]   s_data = '0;
  logic          cfg_alt = 1'b0, cfg_pol = 1'b0, cfg_dis = 1'b0;
  logic [15:0]   cfg_thr = '0;
  logic [7:0]    cfg_mask = 8'hFF;
  logic          hit_vld, any_hit, mult_vld;
  logic [7:0]    hits;
  logic [3:0]    mult;

  int checks = 0, errors = 0;
  bit done = 0;

  int   mh [NCH][16];
  int   mseen;
  bit   lastv;
  logic [7:0] laste;

  always #2.5 clk = ~clk;

  trg_hit_det u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .cfg_alt(cfg_alt), .cfg_pol(cfg_pol), .cfg_dis(cfg_dis), .cfg_thr(cfg_thr),
    .cfg_mask(cfg_mask), .hit_vld(hit_vld), .hits(hits), .any_hit(any_hit),
    .mult_vld(mult_vld), .mult(mult)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int popc(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic model_step(input logic [79:0] d, output logic [7:0] e);
    logic signed [15:0] ts;
    int t;
    ts = cfg_thr;
    t  = int'(ts);
    e  = '0;
    for (int c = 0; c < NCH; c++) begin
      int x, sn, so, q, h;
      x = cfg_dis ? 0 : int'(d[c*SW +: SW]);
      if (cfg_pol) x = x ^ 1023;
      if (!cfg_alt) begin
        h = ((x - mh[c][2]) >= t) ? 1 : 0;           // R3
      end else begin
        sn = x;
        for (int i = 0; i < 7; i++) sn += mh[c][i];
        so = 0;
        for (int i = 7; i < 15; i++) so += mh[c][i];
        q = (sn - so) >>> 2;                          // R4
        h = (t >= 0) ? ((q >= t) ? 1 : 0) : ((q <= t) ? 1 : 0);
      end
      e[c] = (h != 0) && (mseen >= 15) && cfg_mask[c];
      for (int i = 14; i > 0; i--) mh[c][i] = mh[c][i-1];
      mh[c][0] = x;
    end
    if (mseen < 16) mseen++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    s_valid = 1'b0;
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < 16; i++) mh[c][i] = 0;
    mseen = 0;
    lastv = 0;
    laste = '0;
    repeat (3) @(negedge clk);
    check("R1 hit_vld in reset", int'(hit_vld), 0);
    check("R1 hits in reset", int'(hits), 0);
    check("R1 any_hit in reset", int'(any_hit), 0);
    check("R1 mult_vld in reset", int'(mult_vld), 0);
    check("R1 mult in reset", int'(mult), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 hit_vld after reset", int'(hit_vld), 0);
    check("R2 s_ready", int'(s_ready), 1);
  endtask

  task automatic cycle(input bit v, input logic [79:0] d, input string tag);
    logic [7:0] e;
    e = '0;
    s_valid = v;
    s_data  = d;
    if (v) model_step(d, e);
    @(posedge clk);
    @(negedge clk);
    check("R2 hit_vld", int'(hit_vld), int'(v));
    if (v) begin
      check(tag, int'(hits), int'(e));
      check("R7 any_hit", int'(any_hit), int'(e != 0));
    end
    check("R8 mult_vld", int'(mult_vld), int'(lastv));
    if (lastv) check("R8 mult", int'(mult), popc(laste));
    lastv = v;
    laste = e;
  endtask

  function automatic logic [79:0] rnd_beat();
    logic [79:0] d;
    for (int c = 0; c < NCH; c++) d[c*SW +: SW] = SW'($urandom_range(0, 1023));
    return d;
  endfunction

  initial begin
    int thr_list [6];
    logic [7:0] mask_list [3];
    thr_list = '{-200, -1, 0, 1, 100, 400};
    mask_list = '{8'hFF, 8'h00, 8'hA5};

    do_reset();
    // R6: rising ramp with threshold 0 would hit at once; nothing before beat 16
    cfg_alt = 1'b0; cfg_thr = 16'd0; cfg_mask = 8'hFF;
    for (int n = 0; n < 20; n++) begin
      logic [79:0] d;
      for (int c = 0; c < NCH; c++) d[c*SW +: SW] = SW'(n * 40 + c);
      cycle(1'b1, d, "R6 warm-up hits");
    end

    do_reset();
    for (int a = 0; a < 2; a++)
      for (int p = 0; p < 2; p++)
        for (int z = 0; z < 2; z++)
          for (int ti = 0; ti < 6; ti++)
            for (int mi = 0; mi < 3; mi++) begin
              string tag;
              cfg_alt = a[0]; cfg_pol = p[0]; cfg_dis = z[0];
              cfg_thr = 16'(thr_list[ti]);
              cfg_mask = mask_list[mi];
              if (mask_list[mi] == 8'h00) tag = "R7 masked hits";
              else if (z != 0)            tag = "R5 conditioned hits";
              else if (a != 0)            tag = "R4 windowed hits";
              else                        tag = "R3 step hits";
              for (int n = 0; n < 24; n++)
                cycle($urandom_range(0, 3) != 0, rnd_beat(), tag);
            end
    cycle(1'b0, '0, "R2 drain");
    cycle(1'b0, '0, "R2 drain");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule